// File: doc/BRIEF.md
# Cache Request Admission and Merge Controller

This block stands at the entrance of a cache's incoming-request buffer and classifies every arriving request in the cycle it is presented. A request is one of two kinds, a demand acquire or a prefetch, and it carries a set index and a tag. In that cycle the block compares the request against every miss-handling (MSHR) entry, looks at the conflict flags from the main pipeline stages and at whether the buffered queue is about to dispatch, and chooses one of five outcomes. The request can be merged into an MSHR entry, absorbed (a redundant prefetch is accepted and dropped), written into the buffer, sent straight to the pipeline, or stalled.

The ready handshake is combinational, so a request is accepted in the cycle it is offered. The outcome is held in a small state machine whose state names the result of the previous cycle's request. The states are `ADM_IDLE`, `ADM_STALL`, `ADM_MERGE`, `ADM_ABSORB`, `ADM_ALLOC` and `ADM_BYPASS`. Each clock edge picks the next state from the current request. No request gives `ADM_IDLE`. A request that is offered but refused gives `ADM_STALL`. An accepted request moves to the state named after its outcome. The merge task, the allocate strobe and the bypass strobe are decoded from that state, so each is a single-cycle pulse in the cycle that follows the handshake.

The buffer storage and the internals of the MSHR entries belong to other blocks.

Top module: `req_admit_top`

## Requirements
- R1: An acquire whose set and tag both equal those of a valid MSHR entry marked prefetch is merged. One cycle after the handshake, `merge_task` is one-hot on that entry, and `alloc_pulse` and `bypass_pulse` stay low.
- R2: If several valid prefetch entries match an acquire, the merge goes to the entry with the lowest index.
- R3: `req_ready` is high whenever `buf_full` is low.
- R4: With `buf_full` high, `req_ready` is high for an acquire that can be merged as in R1.
- R5: With `buf_full` high, `req_ready` is high for a prefetch that matches any valid MSHR entry, whatever that entry's kind. The prefetch is dropped: no strobe and no merge task follow.
- R6: `alloc_pulse` rises one cycle after a handshake when the buffer is not full, the request is not merged, and the request is blocked. A request is blocked when any pipeline conflict flag is set, when any valid MSHR matches its address, or when `queue_ready` is high.
- R7: `bypass_pulse` rises one cycle after a handshake when the buffer is not full, the request is not merged, and the request is not blocked.
- R8: When the buffer is full and the request is neither mergeable nor absorbable, `req_ready` is low and no strobe or merge task follows.
- R9: At most one of the merge task, `alloc_pulse` and `bypass_pulse` is active in any cycle. Each lasts one cycle, and none appears without a handshake in the previous cycle.
- R10: Invalid MSHR entries, and entries that match only the set or only the tag, neither merge nor block a request.
- R11: After reset, `merge_task`, `alloc_pulse` and `bypass_pulse` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_is_pf | input | 1 | Request kind: 1 = prefetch, 0 = acquire |
| req_set | input | SET_W | Request set index |
| req_tag | input | TAG_W | Request tag |
| buf_full | input | 1 | The request buffer has no free entry |
| queue_ready | input | 1 | The buffered queue is ready to dispatch this cycle |
| pipe_conflict | input | N_STAGE | Set conflict flags from the main pipeline stages |
| mshr_valid | input | N_MSHR | MSHR entry in use |
| mshr_is_pf | input | N_MSHR | MSHR entry holds a prefetch (1) or an acquire (0) |
| mshr_set | input | N_MSHR x SET_W | Set index per MSHR entry |
| mshr_tag | input | N_MSHR x TAG_W | Tag per MSHR entry |
| req_ready | output | 1 | The request is accepted this cycle |
| merge_task | output | N_MSHR | One-hot merge task to the matched MSHR entry |
| alloc_pulse | output | 1 | Write the accepted request into the buffer |
| bypass_pulse | output | 1 | Send the accepted request straight to the pipeline |

## Verification
`req_ready` is combinational, so the bench checks it in the same cycle as the stimulus. It drives inputs on the falling edge and samples `req_ready` shortly after. The merge task and both strobes come from the state register, so they are due exactly one rising edge after the handshake. The bench reads them on the next falling edge, before it applies the next stimulus. The sweep covers every combination of MSHR valid bits, MSHR kinds, request kind, buffer-full, queue-ready and pipeline conflict flags. It uses a fixed address pattern in which two entries match fully and two match only in part.

// File: rtl/req_admit_pkg.sv
package req_admit_pkg;

    typedef enum logic [2:0] {
        ADM_IDLE   = 3'd0,
        ADM_STALL  = 3'd1,
        ADM_MERGE  = 3'd2,
        ADM_ABSORB = 3'd3,
        ADM_ALLOC  = 3'd4,
        ADM_BYPASS = 3'd5
    } adm_state_e;

    typedef struct packed {
        logic ready;
        logic merge;
        logic absorb;
        logic alloc;
        logic bypass;
    } adm_verdict_t;

endpackage

// File: rtl/adm_addr_match.sv
module adm_addr_match #(
    parameter int N_MSHR = 16,
    parameter int SET_W  = 9,
    parameter int TAG_W  = 20
) (
    input  logic [SET_W-1:0]              req_set,
    input  logic [TAG_W-1:0]              req_tag,
    input  logic [N_MSHR-1:0]             mshr_valid,
    input  logic [N_MSHR-1:0]             mshr_is_pf,
    input  logic [N_MSHR-1:0][SET_W-1:0]  mshr_set,
    input  logic [N_MSHR-1:0][TAG_W-1:0]  mshr_tag,
    output logic [N_MSHR-1:0]             hit_any,
    output logic [N_MSHR-1:0]             hit_pf
);

    // Per-entry comparator: a hit needs a live entry and an exact set+tag match.
    for (genvar g = 0; g < N_MSHR; g++) begin : g_cmp
        logic addr_eq;
        assign addr_eq    = (mshr_set[g] == req_set) && (mshr_tag[g] == req_tag);
        assign hit_any[g] = mshr_valid[g] && addr_eq;
        assign hit_pf[g]  = hit_any[g] && mshr_is_pf[g];
    end

endmodule

// File: rtl/adm_lowest_pick.sv
module adm_lowest_pick #(
    parameter int N     = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so the lowest set bit is the last to write.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/adm_decide.sv
module adm_decide
    import req_admit_pkg::*;
#(
    parameter int N_MSHR  = 16,
    parameter int N_STAGE = 3
) (
    input  logic               req_is_pf,
    input  logic               buf_full,
    input  logic               queue_ready,
    input  logic [N_STAGE-1:0] pipe_conflict,
    input  logic [N_MSHR-1:0]  hit_any,
    input  logic               pf_found,
    output adm_verdict_t       verdict
);

    logic blocked;

    assign blocked = (|pipe_conflict) || (|hit_any) || queue_ready;

    always_comb begin
        verdict.merge  = !req_is_pf && pf_found;
        verdict.absorb = req_is_pf && buf_full && (|hit_any);
        verdict.ready  = !buf_full || verdict.merge || verdict.absorb;
        verdict.alloc  = !buf_full && !verdict.merge && blocked;
        verdict.bypass = !buf_full && !verdict.merge && !blocked;
    end

endmodule

// File: rtl/req_admit_top.sv
module req_admit_top
    import req_admit_pkg::*;
#(
    parameter int N_MSHR  = 16,
    parameter int SET_W   = 9,
    parameter int TAG_W   = 20,
    parameter int N_STAGE = 3,
    localparam int IDX_W  = (N_MSHR > 1) ? $clog2(N_MSHR) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_is_pf,
    input  logic [SET_W-1:0]              req_set,
    input  logic [TAG_W-1:0]              req_tag,
    input  logic                          buf_full,
    input  logic                          queue_ready,
    input  logic [N_STAGE-1:0]            pipe_conflict,
    input  logic [N_MSHR-1:0]             mshr_valid,
    input  logic [N_MSHR-1:0]             mshr_is_pf,
    input  logic [N_MSHR-1:0][SET_W-1:0]  mshr_set,
    input  logic [N_MSHR-1:0][TAG_W-1:0]  mshr_tag,
    output logic                          req_ready,
    output logic [N_MSHR-1:0]             merge_task,
    output logic                          alloc_pulse,
    output logic                          bypass_pulse
);

    logic [N_MSHR-1:0] hit_any;
    logic [N_MSHR-1:0] hit_pf;
    logic              pf_found;
    logic [IDX_W-1:0]  pf_idx;
    adm_verdict_t      verdict;

    adm_state_e        state_q, state_d;
    logic [IDX_W-1:0]  merge_idx_q;

    adm_addr_match #(
        .N_MSHR (N_MSHR),
        .SET_W  (SET_W),
        .TAG_W  (TAG_W)
    ) u_match (
        .req_set    (req_set),
        .req_tag    (req_tag),
        .mshr_valid (mshr_valid),
        .mshr_is_pf (mshr_is_pf),
        .mshr_set   (mshr_set),
        .mshr_tag   (mshr_tag),
        .hit_any    (hit_any),
        .hit_pf     (hit_pf)
    );

    adm_lowest_pick #(
        .N (N_MSHR)
    ) u_pick (
        .req_vec (hit_pf),
        .found   (pf_found),
        .idx     (pf_idx)
    );

    adm_decide #(
        .N_MSHR  (N_MSHR),
        .N_STAGE (N_STAGE)
    ) u_decide (
        .req_is_pf     (req_is_pf),
        .buf_full      (buf_full),
        .queue_ready   (queue_ready),
        .pipe_conflict (pipe_conflict),
        .hit_any       (hit_any),
        .pf_found      (pf_found),
        .verdict       (verdict)
    );

    assign req_ready = verdict.ready;

    // Next-state selection: the state records the outcome of this cycle's request.
    always_comb begin
        state_d = ADM_IDLE;
        if (req_valid) begin
            if (!verdict.ready)      state_d = ADM_STALL;
            else if (verdict.merge)  state_d = ADM_MERGE;
            else if (verdict.absorb) state_d = ADM_ABSORB;
            else if (verdict.alloc)  state_d = ADM_ALLOC;
            else                     state_d = ADM_BYPASS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ADM_IDLE;
            merge_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid && verdict.merge) merge_idx_q <= pf_idx;
        end
    end

    // Output decode from the state register.
    always_comb begin
        merge_task   = '0;
        alloc_pulse  = 1'b0;
        bypass_pulse = 1'b0;
        unique case (state_q)
            ADM_MERGE:  merge_task[merge_idx_q] = 1'b1;
            ADM_ALLOC:  alloc_pulse  = 1'b1;
            ADM_BYPASS: bypass_pulse = 1'b1;
            ADM_IDLE, ADM_STALL, ADM_ABSORB: ;
            default: ;
        endcase
    end

    AST_MERGE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(merge_task)); // R1
    AST_MERGE_TO_PF: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_is_pf && (|(hit_pf & ~(hit_pf - 1'b1)))
        |=> merge_task == $past(hit_pf & ~(hit_pf - 1'b1))); // R2
    AST_FULL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && buf_full |=> !alloc_pulse && !bypass_pulse); // R5
    AST_ALLOC_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !buf_full && !pf_found && !(|hit_any)
        && !(|pipe_conflict) && !queue_ready |=> bypass_pulse); // R7
    AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> (merge_task == '0) && !alloc_pulse && !bypass_pulse); // R8
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({|merge_task, alloc_pulse, bypass_pulse}) <= 1); // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (merge_task == '0) && !alloc_pulse && !bypass_pulse); // R9
    AST_READY_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_full |-> req_ready); // R3

endmodule

// File: tb/req_admit_top_tb_top.sv
`timescale 1ns/1ps
module req_admit_top_tb_top;

    localparam int NM = 4;
    localparam int SW = 3;
    localparam int TW = 3;
    localparam int NS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_is_pf = 1'b0;
    logic [SW-1:0] req_set = 3'd5;
    logic [TW-1:0] req_tag = 3'd2;
    logic buf_full = 1'b0;
    logic queue_ready = 1'b0;
    logic [NS-1:0] pipe_conflict = '0;
    logic [NM-1:0] mshr_valid = '0;
    logic [NM-1:0] mshr_is_pf = '0;
    logic [NM-1:0][SW-1:0] mshr_set;
    logic [NM-1:0][TW-1:0] mshr_tag;
    logic req_ready;
    logic [NM-1:0] merge_task;
    logic alloc_pulse;
    logic bypass_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    req_admit_top #(.N_MSHR(NM), .SET_W(SW), .TAG_W(TW), .N_STAGE(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_pf(req_is_pf),
        .req_set(req_set), .req_tag(req_tag), .buf_full(buf_full),
        .queue_ready(queue_ready), .pipe_conflict(pipe_conflict),
        .mshr_valid(mshr_valid), .mshr_is_pf(mshr_is_pf),
        .mshr_set(mshr_set), .mshr_tag(mshr_tag), .req_ready(req_ready),
        .merge_task(merge_task), .alloc_pulse(alloc_pulse), .bypass_pulse(bypass_pulse)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Entry 0: set only; 1: full match; 2: tag only; 3: full match.
    initial begin
        mshr_set = '{3'd5, 3'd3, 3'd5, 3'd5};
        mshr_tag = '{3'd2, 3'd2, 3'd2, 3'd1};
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 merge", int'(merge_task), 0);
        chk("R11 alloc", int'(alloc_pulse), 0);
        chk("R11 bypass", int'(bypass_pulse), 0);

        for (int v = 0; v < 16; v++)
        for (int t = 0; t < 16; t++)
        for (int k = 0; k < 2; k++)
        for (int f = 0; f < 2; f++)
        for (int q = 0; q < 2; q++)
        for (int p = 0; p < 8; p++) begin
            logic [3:0] m, pm;
            logic e_merge, e_absorb, e_ready, e_block, e_alloc, e_bypass;
            int e_task;
            mshr_valid = 4'(v); mshr_is_pf = 4'(t);
            req_is_pf = k[0]; buf_full = f[0]; queue_ready = q[0];
            pipe_conflict = 3'(p); req_valid = 1'b1;
            m  = 4'(v) & 4'b1010;
            pm = m & 4'(t);
            e_merge  = !k[0] && (pm != 0);
            e_absorb = k[0] && f[0] && (m != 0);
            e_ready  = !f[0] || e_merge || e_absorb;
            e_block  = (p != 0) || (m != 0) || q[0];
            e_alloc  = !f[0] && !e_merge && e_block;
            e_bypass = !f[0] && !e_merge && !e_block;
            e_task   = !e_merge ? 0 : (pm[1] ? 2 : 8);
            #1;
            chk(!f[0] ? "R3 ready" : e_merge ? "R4 ready" : e_absorb ? "R5 ready" : "R8 ready",
                int'(req_ready), int'(e_ready));
            @(negedge clk);
            chk((pm == 4'b1010) ? "R2 merge" : (m == 0 && v != 0) ? "R10 merge" : "R1 merge",
                int'(merge_task), e_task);
            chk("R6 alloc", int'(alloc_pulse), int'(e_alloc));
            chk((m == 0 && v != 0) ? "R10 bypass" : "R7 bypass", int'(bypass_pulse), int'(e_bypass));
        end

        // Idle cycle after a strobe: nothing may follow without a request.
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 merge", int'(merge_task), 0);
        chk("R9 alloc", int'(alloc_pulse), 0);
        chk("R9 bypass", int'(bypass_pulse), 0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule